// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides, for every incoming frame, whether the frame's 48-bit destination address is one the station wants. The receive datapath presents the destination address together with a CRC-32 already computed over it, raises a one-cycle strobe, and one clock later gets a registered accept decision plus a small set of classification flags. The block computes no CRC and handles no DMA or frame storage.

The decision draws on three sources. The first is a table of four exact-match address slots: slot 0 is meant for the station's own unicast address and slots 1 to 3 for up to three group addresses. The second is a 64-bin group-address hash table indexed by the top six CRC bits. The third is a pair of control bits for promiscuous reception and hash enable. All of this state is loaded through a 16-bit write-only register port. Broadcast is always taken. When several slots hold the same address, the lowest-numbered slot is reported.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset the control bits, hash words and slots are all zero and every classification output is low. With that state a broadcast frame is still accepted, and a frame addressed to all zeros is rejected.
- R2: `cls_valid` is high exactly in the cycle after a cycle with `da_valid` high. The flags and `accept` are registered, and they remain steady while `cls_valid` is low.
- R3: The all-ones address sets `st_bcast` and `accept`. A broadcast never raises `st_mcast` or `st_hash_hit`.
- R4: Slot k is written at byte offset 0x20 + 8·k. Offset +0 holds address bits 15:0, +2 holds bits 31:16 and +4 holds bits 47:32. The first byte on the wire is address bits 7:0. An equal address sets `accept` and `st_exact_hit`, and `st_slot` gives k. `st_slot` is 0 when there is no exact hit.
- R5: A slot that holds all zeros never matches.
- R6: When several slots match, `st_slot` reports the lowest-numbered one.
- R7: The hash index is CRC bits 31:26. Hash word i (i = index bits 5:4) is written at offset 0x10 + 2·i, and index bits 3:0 select the bit within it. `st_hash_hit` and a hash-based accept require control bit 8 set and a non-broadcast group address (address bit 0 set).
- R8: With control bit 8 clear, a set hash bit neither raises `st_hash_hit` nor causes an accept.
- R9: Control register offset 0x00 bit 5 forces `accept` for every frame. The classification flags are still reported as usual.
- R10: A group address that misses both the slots and the hash is rejected. A unicast address is never accepted through the hash.
- R11: Writes to unmapped offsets change nothing. A frame presented in the same cycle as a table write is classified against the contents before the write.
- R12: With hash enabled and all four hash words set to 0xFFFF, every non-broadcast group address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 16 | Register write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, first wire byte in bits 7:0 |
| da_crc | input | 32 | CRC-32 of the destination address |
| cls_valid | output | 1 | Classification valid |
| accept | output | 1 | Frame accepted |
| st_bcast | output | 1 | Broadcast address seen |
| st_mcast | output | 1 | Non-broadcast group address seen |
| st_hash_hit | output | 1 | Group hash bin hit |
| st_exact_hit | output | 1 | Exact-match slot hit |
| st_slot | output | 2 | Index of the matching slot |

## Verification
A slot word that lands in the wrong position, or a hash bit decoded from the wrong word, appears on the very next classification as a missing `st_exact_hit` or `st_hash_hit`, or as a wrong `st_slot`. The error never waits more than one cycle after the strobe. A stale or wrongly decoded control bit shows up as an `accept` that disagrees with the flags: a missing or unexpected promiscuous accept, or hash hits that appear while the hash is disabled. A broken priority encoder only shows when two slots hold the same address, so the tests deliberately load duplicates and then rewrite the lower slot.

// File: rtl/afl_pkg.sv
package afl_pkg;
    localparam int ADDR_W       = 8;
    localparam int WORD_W       = 16;
    localparam int MAC_W        = 48;
    localparam int CRC_W        = 32;
    localparam int WORDS_PER_MAC = MAC_W / WORD_W;

    // register map (byte offsets)
    localparam int CTRL_OFS     = 'h00;
    localparam int HASH_OFS     = 'h10;
    localparam int SLOT_OFS     = 'h20;
    localparam int SLOT_STRIDE  = 8;

    // control bit positions
    localparam int PROMISC_BIT  = 5;
    localparam int HASHEN_BIT   = 8;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/afl_regs.sv
module afl_regs
    import afl_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int HASH_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [WORD_W-1:0]       wr_data,
    output logic                    promisc,
    output logic                    hash_en,
    output logic [SLOTS*MAC_W-1:0]  slot_tab,
    output logic [2**HASH_W-1:0]    hash_tab
);
    localparam int HBITS  = 2**HASH_W;
    localparam int HWORDS = HBITS / WORD_W;

    typedef struct packed {
        logic                   promisc;
        logic                   hash_en;
        logic [HBITS-1:0]       hash;
        logic [SLOTS*MAC_W-1:0] slots;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(CTRL_OFS)) begin
                r_d.promisc = wr_data[PROMISC_BIT];
                r_d.hash_en = wr_data[HASHEN_BIT];
            end
            for (int w = 0; w < HWORDS; w++) begin
                if (wr_addr == ADDR_W'(HASH_OFS + 2*w))
                    r_d.hash[w*WORD_W +: WORD_W] = wr_data;
            end
            for (int k = 0; k < SLOTS; k++) begin
                for (int j = 0; j < WORDS_PER_MAC; j++) begin
                    if (wr_addr == ADDR_W'(SLOT_OFS + SLOT_STRIDE*k + 2*j))
                        r_d.slots[k*MAC_W + j*WORD_W +: WORD_W] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign promisc  = r_q.promisc;
    assign hash_en  = r_q.hash_en;
    assign slot_tab = r_q.slots;
    assign hash_tab = r_q.hash;

    AST_TABLES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(hash_tab) && $stable(slot_tab) && $stable(promisc) && $stable(hash_en))); // R11
endmodule

// File: rtl/afl_exact.sv
module afl_exact
    import afl_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int IW    = 2
) (
    input  logic [MAC_W-1:0]        da,
    input  logic [SLOTS*MAC_W-1:0]  slot_tab,
    output logic                    hit,
    output logic [IW-1:0]           idx
);
    logic [SLOTS-1:0] match;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        logic [MAC_W-1:0] entry;
        assign entry    = slot_tab[k*MAC_W +: MAC_W];
        assign match[k] = (entry != '0) && (entry == da);
    end

    always_comb begin
        hit = |match;
        idx = '0;
        for (int k = SLOTS-1; k >= 0; k--) begin
            if (match[k]) idx = IW'(k);
        end
    end
endmodule

// File: rtl/afl_hash.sv
module afl_hash
    import afl_pkg::*;
#(
    parameter int HASH_W = 6
) (
    input  logic [CRC_W-1:0]     crc,
    input  logic [2**HASH_W-1:0] hash_tab,
    output logic                 bin_set
);
    logic [HASH_W-1:0] bin;
    logic              unused_crc_low;

    assign bin            = crc[CRC_W-1 -: HASH_W];
    assign bin_set        = hash_tab[bin];
    assign unused_crc_low = ^crc[CRC_W-HASH_W-1:0];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import afl_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int HASH_W = 6,
    localparam int IW    = idx_width(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              da_valid,
    input  logic [47:0]       da,
    input  logic [31:0]       da_crc,
    output logic              cls_valid,
    output logic              accept,
    output logic              st_bcast,
    output logic              st_mcast,
    output logic              st_hash_hit,
    output logic              st_exact_hit,
    output logic [IW-1:0]     st_slot
);
    typedef struct packed {
        logic          valid;
        logic          accept;
        logic          bcast;
        logic          mcast;
        logic          hhit;
        logic          ehit;
        logic [IW-1:0] slot;
    } cls_t;

    logic                   promisc, hash_en;
    logic [SLOTS*MAC_W-1:0] slot_tab;
    logic [2**HASH_W-1:0]   hash_tab;
    logic                   ex_hit, bin_set;
    logic [IW-1:0]          ex_idx;
    cls_t                   c_d, c_q;

    afl_regs #(.SLOTS(SLOTS), .HASH_W(HASH_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .promisc(promisc), .hash_en(hash_en),
        .slot_tab(slot_tab), .hash_tab(hash_tab)
    );

    afl_exact #(.SLOTS(SLOTS), .IW(IW)) exact_i (
        .da(da), .slot_tab(slot_tab), .hit(ex_hit), .idx(ex_idx)
    );

    afl_hash #(.HASH_W(HASH_W)) hash_i (
        .crc(da_crc), .hash_tab(hash_tab), .bin_set(bin_set)
    );

    always_comb begin
        logic is_bc, is_grp;
        c_d       = c_q;
        c_d.valid = da_valid;
        is_bc     = &da;
        is_grp    = da[0] && !is_bc;
        if (da_valid) begin
            c_d.bcast  = is_bc;
            c_d.mcast  = is_grp;
            c_d.hhit   = hash_en && is_grp && bin_set;
            c_d.ehit   = ex_hit;
            c_d.slot   = ex_idx;
            c_d.accept = promisc || is_bc || ex_hit || (hash_en && is_grp && bin_set);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cls_valid    = c_q.valid;
    assign accept       = c_q.accept;
    assign st_bcast     = c_q.bcast;
    assign st_mcast     = c_q.mcast;
    assign st_hash_hit  = c_q.hhit;
    assign st_exact_hit = c_q.ehit;
    assign st_slot      = c_q.slot;

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |=> cls_valid); // R2
    AST_VALID_ONLY_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> !cls_valid); // R2
    AST_FLAGS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> ($stable(accept) && $stable(st_slot) && $stable(st_exact_hit))); // R2
    AST_BCAST_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_valid && st_bcast) |-> (accept && !st_mcast && !st_hash_hit)); // R3
    AST_SLOT_ZERO_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_valid && !st_exact_hit) |-> (st_slot == '0)); // R4
    AST_HASH_NEEDS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        st_hash_hit |-> st_mcast); // R7
    AST_HASH_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && !hash_en) |=> !st_hash_hit); // R8
    AST_PROMISC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && promisc) |=> accept); // R9
endmodule

// File: tb/rx_addr_filter_tb.sv
`timescale 1ns/1ps
module rx_addr_filter_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        da_valid = 0;
    logic [47:0] da = '0;
    logic [31:0] da_crc = '0;
    logic        cls_valid, accept, st_bcast, st_mcast, st_hash_hit, st_exact_hit;
    logic [1:0]  st_slot;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rx_addr_filter dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .da_valid(da_valid), .da(da), .da_crc(da_crc), .cls_valid(cls_valid),
        .accept(accept), .st_bcast(st_bcast), .st_mcast(st_mcast),
        .st_hash_hit(st_hash_hit), .st_exact_hit(st_exact_hit), .st_slot(st_slot)
    );

    // expected = {accept, bcast, mcast, hash_hit, exact_hit, slot[1:0]}
    typedef struct packed {
        logic [47:0] addr;
        logic [31:0] crc;
        logic [6:0]  exp;
    } vec_t;

    localparam logic [47:0] OWN_MAC  = 48'h5544_3322_1100;
    localparam logic [47:0] GRP_MAC  = 48'h0100_005E_0001;
    localparam logic [31:0] CRC_B42  = 32'hA800_0000;

    localparam vec_t VECS [9] = '{
        '{OWN_MAC,              32'h0,          7'b1_0_0_0_1_00}, // R4 slot 0
        '{GRP_MAC,              32'h0,          7'b1_0_1_0_1_01}, // R6 slots 1 and 3
        '{48'hFFFF_FFFF_FFFF,   CRC_B42,        7'b1_1_0_0_0_00}, // R3
        '{48'h0000_0000_0003,   CRC_B42,        7'b1_0_1_1_0_00}, // R7 bin 42
        '{48'h0000_0000_0003,   32'h0,          7'b0_0_1_0_0_00}, // R10 bin 0 clear
        '{48'h0000_0000_0003,   32'hA7FF_FFFF,  7'b0_0_1_0_0_00}, // R10 bin 41 clear
        '{48'h0000_0000_0002,   CRC_B42,        7'b0_0_0_0_0_00}, // R10 unicast
        '{48'h0000_0000_0000,   32'h0,          7'b0_0_0_0_0_00}, // R5 zero slot 2
        '{48'h5644_3322_1100,   32'h0,          7'b0_0_0_0_0_00}  // R4 near miss
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic wr_slot(input int k, input logic [47:0] m);
        wr(8'(8'h20 + 8*k),     m[15:0]);
        wr(8'(8'h20 + 8*k + 2), m[31:16]);
        wr(8'(8'h20 + 8*k + 4), m[47:32]);
    endtask

    function automatic logic [6:0] got();
        return {accept, st_bcast, st_mcast, st_hash_hit, st_exact_hit, st_slot};
    endfunction

    task automatic classify(input logic [47:0] a, input logic [31:0] c);
        @(negedge clk);
        da_valid = 1; da = a; da_crc = c;
        @(negedge clk);
        da_valid = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 outputs after reset", {25'd0, got()}, 32'd0);
        chk("R1 valid after reset", {31'd0, cls_valid}, 32'd0);
        classify(48'hFFFF_FFFF_FFFF, 32'h0);
        chk("R1 broadcast with empty tables", {25'd0, got()}, {25'd0, 7'b1_1_0_0_0_00});
        classify(48'h0, 32'h0);
        chk("R1 zero address rejected", {25'd0, got()}, 32'd0);

        // R2 latency
        @(negedge clk);
        da_valid = 1; da = OWN_MAC; da_crc = 0;
        chk("R2 valid low in strobe cycle", {31'd0, cls_valid}, 32'd0);
        @(negedge clk);
        da_valid = 0;
        chk("R2 valid one cycle later", {31'd0, cls_valid}, 32'd1);
        @(negedge clk);
        chk("R2 valid single cycle", {31'd0, cls_valid}, 32'd0);

        // configuration
        wr_slot(0, OWN_MAC);
        wr_slot(1, GRP_MAC);
        wr_slot(3, GRP_MAC);
        wr(8'h14, 16'h0400);
        wr(8'h00, 16'h0100);

        foreach (VECS[i]) begin
            classify(VECS[i].addr, VECS[i].crc);
            chk($sformatf("R4/R7 vector %0d", i), {25'd0, got()}, {25'd0, VECS[i].exp});
            chk($sformatf("R2 vector %0d valid", i), {31'd0, cls_valid}, 32'd1);
        end

        // R6 slot 3 alone after slot 1 is changed
        wr(8'h28, 16'h0003);
        classify(GRP_MAC, 32'h0);
        chk("R6 slot 3 hit", {25'd0, got()}, {25'd0, 7'b1_0_1_0_1_11});

        // R8 hash disabled
        wr(8'h00, 16'h0000);
        classify(48'h0000_0000_0003, CRC_B42);
        chk("R8 hash disabled", {25'd0, got()}, {25'd0, 7'b0_0_1_0_0_00});

        // R9 promiscuous
        wr(8'h00, 16'h0020);
        classify(48'h0000_0000_0002, 32'h0);
        chk("R9 promisc unicast", {25'd0, got()}, {25'd0, 7'b1_0_0_0_0_00});
        classify(OWN_MAC, 32'h0);
        chk("R9 promisc flags", {25'd0, got()}, {25'd0, 7'b1_0_0_0_1_00});
        wr(8'h00, 16'h0000);

        // R11 unmapped writes
        wr(8'h08, 16'hFFFF);
        wr(8'h3E, 16'hFFFF);
        wr(8'h01, 16'hFFFF);
        classify(48'h0000_0000_0002, 32'h0);
        chk("R11 unmapped no promisc", {25'd0, got()}, 32'd0);
        classify(48'h0000_0000_0003, CRC_B42);
        chk("R11 unmapped no hash enable", {25'd0, got()}, {25'd0, 7'b0_0_1_0_0_00});

        // R11 same-cycle write uses old contents
        @(negedge clk);
        wr_en = 1; wr_addr = 8'h20; wr_data = 16'hAAAA;
        da_valid = 1; da = OWN_MAC; da_crc = 0;
        @(negedge clk);
        wr_en = 0; da_valid = 0;
        chk("R11 old contents used", {25'd0, got()}, {25'd0, 7'b1_0_0_0_1_00});
        classify(OWN_MAC, 32'h0);
        chk("R11 write took effect", {25'd0, got()}, 32'd0);

        // R12 all-ones hash
        wr(8'h00, 16'h0100);
        for (int w = 0; w < 4; w++) wr(8'(8'h10 + 2*w), 16'hFFFF);
        classify(48'h0000_0000_0003, 32'h0);
        chk("R12 all multicast bin 0", {25'd0, got()}, {25'd0, 7'b1_0_1_1_0_00});
        classify(48'h0000_0000_00F1, 32'h5000_0000);
        chk("R12 all multicast bin 20", {25'd0, got()}, {25'd0, 7'b1_0_1_1_0_00});
        classify(48'h0000_0000_0002, 32'h5000_0000);
        chk("R10 unicast not via hash", {25'd0, got()}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule